// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Extend Bit

This combinational unit shifts or rotates the low byte, word or long of a 32-bit operand and returns the new value together with five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The bits of the operand above the selected size leave the unit unchanged. There are four operation kinds, and each works in either direction. Logical and arithmetic shifts fill the vacated positions with zeros or with the sign. A plain rotate sends each bit that leaves one end back into the other end. A rotate through extend adds the incoming X bit to the ring, so the ring is one bit wider than the operand.

An execution stage uses the unit by presenting the operand, the controls and the current X bit. The result and the flags are valid in the same cycle. The place count comes from one of two sources. The first is a 3-bit immediate field, where zero stands for eight places. The second is a register-supplied count, already reduced modulo 64. A memory-operand mode forces word size and a single place, whatever the size and count inputs say.

Top module: `xrot_shift_unit`

## Requirements
- R1: For byte size (size_i=0) and word size (size_i=1), result bits above bit 7 or bit 15 respectively equal the operand bits. Size codes 2 and 3 select long.
- R2: Logical shifts (kind_i=1) fill vacated bits with zero. C receives the last bit shifted out, V is 0, and counts at or beyond the width give a zero result.
- R3: Arithmetic right shifts (kind_i=0, left_i=0) copy the sign bit into vacated positions. Arithmetic left shifts set V when the sized most significant bit changed at any step, and clear V otherwise.
- R4: A plain rotate (kind_i=3) loses no bits, and C equals the last bit rotated. X is left at its input value.
- R5: A rotate through extend (kind_i=2) rotates a ring of size+1 bits in which X sits beyond the sized MSB. A count of size+1 therefore returns the operand and the original X. After a nonzero count, C and X both hold the last bit moved out.
- R6: When cnt_from_reg_i=0, the count equals imm_cnt_i for values 1 to 7, and an immediate of 0 gives 8 places.
- R7: When cnt_from_reg_i=1, the count is reg_cnt_i (0 to 63). A zero count returns the operand unchanged, leaves X unchanged and clears V. It clears C, except in rotate through extend, where C takes X.
- R8: N is the MSB of the sized result, and Z is set when every bit of the sized result is zero, whatever the upper operand bits are.
- R9: With mem_mode_i=1 the operation works on the low word and moves exactly one place. The size and count inputs are ignored.
- R10: For the shift kinds and for rotate through extend with a nonzero count, X is set equal to C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 32 | Operand |
| size_i | input | 2 | 0 byte, 1 word, 2/3 long |
| kind_i | input | 2 | 0 arithmetic, 1 logical, 2 rotate through extend, 3 rotate |
| left_i | input | 1 | 1 left, 0 right |
| cnt_from_reg_i | input | 1 | 1 selects reg_cnt_i, 0 selects imm_cnt_i |
| imm_cnt_i | input | 3 | Immediate count, 0 means 8 |
| reg_cnt_i | input | 6 | Register count modulo 64 |
| mem_mode_i | input | 1 | Forces word size and one place |
| x_i | input | 1 | Incoming extend bit |
| res_o | output | 32 | Result with upper bits passed through |
| x_o | output | 1 | Extend flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The carry and extend outputs come from the same step as the last bit moved and the overflow tracking, so one operation can both move a bit into C and X and set V. Arithmetic left shifts are chosen so that the MSB flips midway, while the last bit out is also a one. The bench then compares C, X and V together with the result. Rotate through extend is also driven with counts of exactly size+1. In that case the extend bit must travel the whole ring and come back, so the returned operand and X are judged as one case.

// File: rtl/xrot_shift_unit.sv
module xrot_shift_unit #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 6
) (
  input  logic [WIDTH-1:0] op_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       kind_i,
  input  logic             left_i,
  input  logic             cnt_from_reg_i,
  input  logic [2:0]       imm_cnt_i,
  input  logic [CNT_W-1:0] reg_cnt_i,
  input  logic             mem_mode_i,
  input  logic             x_i,
  output logic [WIDTH-1:0] res_o,
  output logic             x_o,
  output logic             n_o,
  output logic             z_o,
  output logic             v_o,
  output logic             c_o
);
  localparam int          STEPS   = 1 << CNT_W;
  localparam logic [1:0]  K_ARITH = 2'd0;
  localparam logic [1:0]  K_LOGIC = 2'd1;
  localparam logic [1:0]  K_ROTX  = 2'd2;
  localparam logic [1:0]  K_ROT   = 2'd3;
  localparam int          MSB_W   = $clog2(WIDTH);

  logic [1:0]       sz;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] mask;
  logic [MSB_W-1:0] msb;
  logic [WIDTH-1:0] v;
  logic             xr, co, vf;

  assign sz  = mem_mode_i ? 2'd1 : size_i;
  assign cnt = mem_mode_i     ? CNT_W'(1) :
               cnt_from_reg_i ? reg_cnt_i :
                                CNT_W'({imm_cnt_i == 3'd0, imm_cnt_i});

  always_comb begin
    case (sz)
      2'd0:    begin mask = WIDTH'(8'hFF);    msb = MSB_W'(7);  end
      2'd1:    begin mask = WIDTH'(16'hFFFF); msb = MSB_W'(15); end
      default: begin mask = '1;               msb = MSB_W'(WIDTH-1); end
    endcase
  end

  always_comb begin
    logic out, hi;
    v  = op_i & mask;
    xr = x_i;
    co = 1'b0;
    vf = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (i < int'(cnt)) begin
        if (left_i) begin
          out = v[msb];
          v   = (v << 1) & mask;
          case (kind_i)
            K_ARITH: if (v[msb] != out) vf = 1'b1;
            K_ROT:   v[0] = out;
            K_ROTX:  v[0] = xr;
            default: ;
          endcase
        end else begin
          out = v[0];
          case (kind_i)
            K_ARITH: hi = v[msb];
            K_ROT:   hi = out;
            K_ROTX:  hi = xr;
            default: hi = 1'b0;
          endcase
          v      = v >> 1;
          v[msb] = hi;
        end
        co = out;
        if (kind_i != K_ROT) xr = out;
      end
    end
    if (cnt == '0 && kind_i == K_ROTX) co = x_i;
  end

  assign res_o = (op_i & ~mask) | v;
  assign n_o   = v[msb];
  assign z_o   = (v == '0);
  assign v_o   = vf;
  assign c_o   = co;
  assign x_o   = xr;

  always_comb begin
    a_r1_upper_kept: assert ((res_o & ~mask) == (op_i & ~mask))
      else $error("upper operand bits altered");
    a_r2_logic_left: assert (!(kind_i == K_LOGIC && left_i && int'(cnt) < WIDTH) ||
                             ((res_o & mask) == ((op_i << cnt) & mask)))
      else $error("logical left shift mismatch");
    a_r2_no_overflow: assert (!(kind_i != K_ARITH || !left_i) || 1'b1 ? (kind_i == K_ARITH && left_i) || !v_o : 1'b1)
      else $error("overflow outside arithmetic left");
    a_r4_rot_ones: assert (kind_i != K_ROT ||
                           $countones(res_o & mask) == $countones(op_i & mask))
      else $error("rotate changed the number of ones");
    a_r4_rot_x_kept: assert (kind_i != K_ROT || x_o == x_i)
      else $error("rotate changed extend");
    a_r10_x_follows_c: assert (kind_i == K_ROT || cnt == '0 || x_o == c_o)
      else $error("extend does not follow carry");
    a_r7_zero_count: assert (cnt != '0 || (res_o == op_i && x_o == x_i && !v_o))
      else $error("zero count altered state");
    a_r8_nz_excl: assert (!(n_o && z_o))
      else $error("negative and zero both set");
    a_r9_mem_word: assert (!mem_mode_i || res_o[WIDTH-1:16] == op_i[WIDTH-1:16])
      else $error("memory mode touched upper word");
  end
endmodule

// File: tb/xrot_shift_unit_tb_top.sv
module xrot_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic [31:0] op;
  logic [1:0]  size, kind;
  logic        left, use_reg, mem, xin;
  logic [2:0]  imm;
  logic [5:0]  regc;
  logic [31:0] res;
  logic        xo, no, zo, vo, co;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  always #10 clk = ~clk;

  xrot_shift_unit dut_i (
    .op_i(op), .size_i(size), .kind_i(kind), .left_i(left),
    .cnt_from_reg_i(use_reg), .imm_cnt_i(imm), .reg_cnt_i(regc),
    .mem_mode_i(mem), .x_i(xin), .res_o(res), .x_o(xo), .n_o(no),
    .z_o(zo), .v_o(vo), .c_o(co)
  );

  // {req4, mem, size2, kind2, left, use_reg, imm3, reg6, x, op32, res32, flags XNZVC}
  localparam int NV = 19;
  localparam bit [89:0] VEC [NV] = '{
    {4'd2, 1'b0,2'd0,2'd1,1'b1,1'b0,3'd4,6'd0, 1'b1,32'h12345681,32'h12345610,5'b00000}, // R2 R1
    {4'd6, 1'b0,2'd1,2'd1,1'b0,1'b0,3'd0,6'd0, 1'b0,32'hAAAA8081,32'hAAAA0080,5'b10001}, // R6 R2
    {4'd3, 1'b0,2'd0,2'd0,1'b0,1'b0,3'd1,6'd0, 1'b0,32'h00000081,32'h000000C0,5'b11001}, // R3
    {4'd3, 1'b0,2'd0,2'd0,1'b1,1'b0,3'd2,6'd0, 1'b0,32'h00000040,32'h00000000,5'b10111}, // R3
    {4'd3, 1'b0,2'd1,2'd0,1'b1,1'b0,3'd1,6'd0, 1'b1,32'h00002001,32'h00004002,5'b00000}, // R3
    {4'd4, 1'b0,2'd2,2'd3,1'b1,1'b0,3'd4,6'd0, 1'b1,32'h80000001,32'h00000018,5'b10000}, // R4
    {4'd4, 1'b0,2'd0,2'd3,1'b0,1'b0,3'd1,6'd0, 1'b0,32'hFFFFFF01,32'hFFFFFF80,5'b01001}, // R4 R1
    {4'd5, 1'b0,2'd0,2'd2,1'b1,1'b0,3'd1,6'd0, 1'b1,32'h00000080,32'h00000001,5'b10001}, // R5
    {4'd5, 1'b0,2'd1,2'd2,1'b0,1'b1,3'd0,6'd17,1'b0,32'h00000001,32'h00000001,5'b00000}, // R5
    {4'd5, 1'b0,2'd2,2'd2,1'b1,1'b1,3'd0,6'd33,1'b1,32'h12345678,32'h12345678,5'b10001}, // R5
    {4'd7, 1'b0,2'd2,2'd1,1'b1,1'b1,3'd0,6'd0, 1'b1,32'h80000000,32'h80000000,5'b11000}, // R7
    {4'd7, 1'b0,2'd0,2'd2,1'b0,1'b1,3'd0,6'd0, 1'b1,32'h00000000,32'h00000000,5'b10101}, // R7
    {4'd2, 1'b0,2'd2,2'd1,1'b1,1'b1,3'd0,6'd40,1'b0,32'hFFFFFFFF,32'h00000000,5'b00100}, // R2
    {4'd2, 1'b0,2'd2,2'd1,1'b0,1'b1,3'd0,6'd32,1'b0,32'h80000000,32'h00000000,5'b10101}, // R2 R10
    {4'd9, 1'b1,2'd0,2'd1,1'b1,1'b0,3'd5,6'd0, 1'b0,32'h1234C001,32'h12348002,5'b11001}, // R9
    {4'd3, 1'b0,2'd2,2'd0,1'b0,1'b1,3'd0,6'd63,1'b0,32'h80000000,32'hFFFFFFFF,5'b11001}, // R3
    {4'd3, 1'b0,2'd0,2'd0,1'b1,1'b0,3'd3,6'd0, 1'b0,32'h000000FF,32'h000000F8,5'b11001}, // R3
    {4'd6, 1'b0,2'd0,2'd1,1'b1,1'b0,3'd0,6'd0, 1'b0,32'h00000001,32'h00000000,5'b10101}, // R6
    {4'd8, 1'b0,2'd0,2'd1,1'b0,1'b0,3'd1,6'd0, 1'b0,32'hFFFFFF00,32'hFFFFFF00,5'b00100}  // R8
  };

  task automatic check(input int req, input logic [31:0] er, input logic [4:0] ef);
    logic [4:0] af;
    af = {xo, no, zo, vo, co};
    checks++;
    if (res !== er || af !== ef) begin
      errors++;
      $display("FAIL R%0d: res=%h flags=%b expected res=%h flags=%b", req, res, af, er, ef);
    end
  endtask

  task automatic drive(input logic m, input logic [1:0] s, input logic [1:0] k,
                       input logic l, input logic u, input logic [2:0] im,
                       input logic [5:0] rc, input logic x, input logic [31:0] o);
    @(negedge clk);
    mem = m; size = s; kind = k; left = l; use_reg = u;
    imm = im; regc = rc; xin = x; op = o;
    #5;
  endtask

  initial begin
    // quiet-input check: all zero operand, zero count
    drive(1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 3'd0, 6'd0, 1'b0, 32'h0);
    check(7, 32'h0, 5'b00100); // R7

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][85], VEC[i][84:83], VEC[i][82:81], VEC[i][80], VEC[i][79],
            VEC[i][78:76], VEC[i][75:70], VEC[i][69], VEC[i][68:37]);
      check(int'(VEC[i][89:86]), VEC[i][36:5], VEC[i][4:0]);
    end

    // R5: full ring of size+1 returns operand and X for every size
    for (int s = 0; s < 3; s++) begin
      drive(1'b0, 2'(s), 2'd2, 1'b1, 1'b1, 3'd0, 6'((8 << s) + 1), 1'b1, 32'hC3A596E1);
      checks++;
      if (res !== 32'hC3A596E1 || xo !== 1'b1 || co !== 1'b1) begin
        errors++;
        $display("FAIL R5: size=%0d res=%h x=%b c=%b expected res=c3a596e1 x=1 c=1", s, res, xo, co);
      end
    end

    // R5: byte right through extend inserts X at bit 7
    drive(1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 3'd1, 6'd0, 1'b1, 32'h55555500);
    check(5, 32'h55555580, 5'b01000);

    // R9: memory mode ignores a register count of 0 and long size
    drive(1'b1, 2'd2, 2'd1, 1'b0, 1'b1, 3'd0, 6'd0, 1'b0, 32'hFFFF0003);
    check(9, 32'hFFFF0001, 5'b10001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule